// File: doc/BRIEF.md
# Even/Odd Sample Demultiplexer

This block takes a full-rate stream of converter samples, one word on every input clock, and spreads it over two parallel output buses that each run at half that rate. The first sample taken after reset counts as odd. Odd samples leave on bus A and even samples leave on bus B. The two words of a pair appear together on the same clock, so a receiver can latch both buses at once and rebuild the full-rate stream by taking A first and then B.

A single forwarded data clock, produced from the input clock, goes with both buses. In single-edge mode it runs at half the input rate. A select input then decides whether the buses change together with its rising edge or with its falling edge. In double-edge mode it runs at a quarter of the input rate and every edge of it marks a new pair.

A decimate mode keeps only bus A, which halves the sample rate. Bus B is then parked at zero and its enable is dropped. Sample codes are offset binary and pass through unchanged. The sample width is a parameter.

Top module: `evod_demux`

## Requirements
- R1: While the synchronous active-high reset is sampled high, bus_a, bus_b, bus_b_en, dclk and pair_valid are all 0.
- R2: Count the samples taken on rising clock edges after reset from 1, so the first is odd. Sample 2n-1 appears on bus_a and sample 2n appears on bus_b. Both words update on the same edge, the one that takes sample 2n, and then hold for two clocks.
- R3: pair_valid stays 0 until the edge that takes the second sample after reset. From that edge it is 1 until the next reset.
- R4: In single-edge mode (ddr_mode=0) with launch_fall=0, dclk toggles on every clock and goes high on each edge where the buses update.
- R5: In single-edge mode with launch_fall=1, dclk toggles on every clock and goes low on each edge where the buses update. Right after the first edge out of reset it is 1.
- R6: In double-edge mode (ddr_mode=1), dclk toggles only on edges where the buses update, which makes its period four input clocks. launch_fall has no effect on it.
- R7: With decimate=1, bus_b is 0 and bus_b_en is 0 from the next edge on, while bus_a keeps carrying the odd samples.
- R8: With decimate=0, bus_b_en is 1 from the first edge after reset.
- R9: Codes are offset binary and are passed unmodified. This includes all zeros (negative full scale), all ones (positive full scale) and the two mid-scale codes 0x7F and 0x80 at 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | SAMPLE_W | Sample word, taken on every rising edge |
| ddr_mode | input | 1 | 1: double-edge forwarded clock; 0: single-edge |
| launch_fall | input | 1 | Single-edge mode: 1 aligns updates with the dclk falling edge |
| decimate | input | 1 | 1: keep only bus A; bus B is zeroed and disabled |
| bus_a | output | SAMPLE_W | Odd samples |
| bus_b | output | SAMPLE_W | Even samples |
| bus_b_en | output | 1 | Bus B output enable |
| dclk | output | 1 | Forwarded data clock |
| pair_valid | output | 1 | First full pair has been loaded |

## Verification
If the phase register is wrong, the odd/even assignment swaps. The bench then sees, within two clocks of reset, the wrong sample on bus_a and a pair boundary shifted by one clock. A stuck or wrongly seeded clock-generator state shows as a dclk level mismatch on the first edge after reset in single-edge mode, and within two edges in double-edge mode. A lost or early pair-valid flag, or a bus B that keeps its data under decimation, is visible at the next clock.

// File: rtl/evod_demux_pkg.sv
package evod_demux_pkg;
  typedef enum logic {PH_ODD = 1'b0, PH_EVEN = 1'b1} phase_e;

  typedef struct packed {
    logic ddr;
    logic fall;
    logic decim;
  } mode_t;
endpackage

// File: rtl/evod_phase.sv
module evod_phase
  import evod_demux_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e phase,
  output logic   pair_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_ODD;
      pair_valid <= 1'b0;
    end else begin
      phase <= (phase == PH_ODD) ? PH_EVEN : PH_ODD;
      if (phase == PH_EVEN) pair_valid <= 1'b1;
    end
  end

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    pair_valid |=> pair_valid); // R3
  AST_VALID_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
    (!pair_valid && phase == PH_ODD) |=> !pair_valid); // R3
endmodule

// File: rtl/evod_capture.sv
module evod_capture
  import evod_demux_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  phase_e              phase,
  input  logic                decimate,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic [SAMPLE_W-1:0] bus_a,
  output logic [SAMPLE_W-1:0] bus_b,
  output logic                bus_b_en
);
  localparam logic [SAMPLE_W-1:0] ZERO_W = '0;

  logic [SAMPLE_W-1:0] odd_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      odd_hold <= ZERO_W;
      bus_a    <= ZERO_W;
      bus_b    <= ZERO_W;
      bus_b_en <= 1'b0;
    end else begin
      bus_b_en <= ~decimate;
      if (phase == PH_ODD) odd_hold <= sample_in;
      if (phase == PH_EVEN) bus_a <= odd_hold;
      if (decimate)              bus_b <= ZERO_W;
      else if (phase == PH_EVEN) bus_b <= sample_in;
    end
  end

  AST_A_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ODD) |=> $stable(bus_a)); // R2
  AST_DECIM_B_OFF: assert property (@(posedge clk) disable iff (rst)
    decimate |=> (bus_b == ZERO_W && !bus_b_en)); // R7
  AST_B_ENABLED: assert property (@(posedge clk) disable iff (rst)
    !decimate |=> bus_b_en); // R8
endmodule

// File: rtl/evod_dclk_gen.sv
module evod_dclk_gen
  import evod_demux_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase,
  input  mode_t  mode,
  output logic   dclk
);
  logic sdr_next;
  logic ddr_next;

  always_comb begin
    sdr_next = (phase == PH_EVEN) ^ mode.fall;
    ddr_next = (phase == PH_EVEN) ? ~dclk : dclk;
  end

  always_ff @(posedge clk) begin
    if (rst) dclk <= 1'b0;
    else     dclk <= mode.ddr ? ddr_next : sdr_next;
  end

  AST_DDR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode.ddr && phase == PH_ODD) |=> $stable(dclk)); // R6
  AST_SDR_RISE_ON_PAIR: assert property (@(posedge clk) disable iff (rst)
    (!mode.ddr && !mode.fall && phase == PH_EVEN) |=> dclk); // R4
  AST_SDR_FALL_ON_PAIR: assert property (@(posedge clk) disable iff (rst)
    (!mode.ddr && mode.fall && phase == PH_EVEN) |=> !dclk); // R5
endmodule

// File: rtl/evod_demux.sv
module evod_demux
  import evod_demux_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic                ddr_mode,
  input  logic                launch_fall,
  input  logic                decimate,
  output logic [SAMPLE_W-1:0] bus_a,
  output logic [SAMPLE_W-1:0] bus_b,
  output logic                bus_b_en,
  output logic                dclk,
  output logic                pair_valid
);
  phase_e phase;
  mode_t  mode;

  assign mode = '{ddr: ddr_mode, fall: launch_fall, decim: decimate};

  evod_phase u_phase (
    .clk(clk), .rst(rst), .phase(phase), .pair_valid(pair_valid)
  );

  evod_capture #(.SAMPLE_W(SAMPLE_W)) u_capture (
    .clk(clk), .rst(rst), .phase(phase), .decimate(mode.decim),
    .sample_in(sample_in), .bus_a(bus_a), .bus_b(bus_b), .bus_b_en(bus_b_en)
  );

  evod_dclk_gen u_dclk (
    .clk(clk), .rst(rst), .phase(phase), .mode(mode), .dclk(dclk)
  );

  AST_PAIR_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    (!$stable(bus_b) && !decimate) |-> $rose(pair_valid) || pair_valid); // R2
endmodule

// File: tb/evod_demux_test.sv
`timescale 1ns/1ps
module evod_demux_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] sample_in = '0;
  logic         ddr_mode = 1'b0, launch_fall = 1'b0, decimate = 1'b0;
  logic [W-1:0] bus_a, bus_b;
  logic         bus_b_en, dclk, pair_valid;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int cyc = 0;

  logic [W-1:0] exp_a, exp_b;
  logic         exp_en, exp_dclk, exp_valid;
  logic [W-1:0] hist[$];
  int           k;
  string        data_req;

  always #2 clk = ~clk;

  evod_demux #(.SAMPLE_W(W)) uut (
    .clk(clk), .rst(rst), .sample_in(sample_in), .ddr_mode(ddr_mode),
    .launch_fall(launch_fall), .decimate(decimate), .bus_a(bus_a),
    .bus_b(bus_b), .bus_b_en(bus_b_en), .dclk(dclk), .pair_valid(pair_valid)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h (k=%0d)", req, what, act, exp, k);
    end
  endtask

  task automatic compare_all(bit in_reset);
    string rb, rc, re;
    rb = in_reset ? "R1" : (decimate ? "R7" : data_req);
    re = in_reset ? "R1" : (decimate ? "R7" : "R8");
    rc = in_reset ? "R1" : (ddr_mode ? "R6" : (launch_fall ? "R5" : "R4"));
    chk(in_reset ? "R1" : data_req, "bus_a", bus_a, exp_a);
    chk(rb, "bus_b", bus_b, exp_b);
    chk(re, "bus_b_en", bus_b_en, exp_en);
    chk(rc, "dclk", dclk, exp_dclk);
    chk(in_reset ? "R1" : "R3", "pair_valid", pair_valid, exp_valid);
  endtask

  task automatic do_reset(bit ddr, bit fall, bit dec);
    @(negedge clk);
    rst = 1'b1; ddr_mode = ddr; launch_fall = fall; decimate = dec;
    repeat (3) @(posedge clk);
    @(negedge clk);
    exp_a = '0; exp_b = '0; exp_en = 0; exp_dclk = 0; exp_valid = 0;
    compare_all(1'b1);
    hist.delete();
    k = 0;
    rst = 1'b0;
  endtask

  // Currently at a negedge: predict the next edge, then drive the sample.
  task automatic step(logic [W-1:0] s);
    hist.push_back(s);
    if (k % 2 == 1) begin
      exp_a = hist[hist.size()-2];
      exp_b = s;
      exp_valid = 1'b1;
    end
    if (decimate) exp_b = '0;
    exp_en = ~decimate;
    if (ddr_mode) exp_dclk = (k % 2 == 1) ? ~exp_dclk : exp_dclk;
    else          exp_dclk = ((k % 2) == 1) ^ launch_fall;
    sample_in = s;
    k++;
    @(negedge clk);
    compare_all(1'b0);
  endtask

  task automatic run(bit ddr, bit fall, bit dec, int n, int kind);
    logic [W-1:0] lfsr = 8'h5A;
    do_reset(ddr, fall, dec);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] s;
      case (kind)
        0: s = W'(i + 1);
        1: begin lfsr = {lfsr[W-2:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]}; s = lfsr; end
        default: case (i % 4)
          0: s = '0; 1: s = '1; 2: s = 8'h7F; default: s = 8'h80;
        endcase
      endcase
      step(s);
    end
  endtask

  initial begin
    data_req = "R2";
    run(0, 0, 0, 20, 0);   // R4 single-edge, rising launch
    run(0, 1, 0, 21, 1);   // R5 single-edge, falling launch
    run(1, 0, 0, 24, 0);   // R6 double-edge
    run(1, 1, 0, 23, 1);   // R6 launch_fall ignored in double-edge mode
    run(0, 0, 1, 18, 1);   // R7 decimate
    run(1, 0, 1, 12, 0);   // R7 decimate, double-edge
    data_req = "R9";
    run(0, 0, 0, 16, 2);   // R9 full-scale and mid-scale codes
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule